// File: doc/BRIEF.md
# Keypad Press-Handling Controller

This block sits between a scanned 4x4 keypad and a two-digit seven-segment display. A row scanner raises a key-detected flag and presents the code of the key it found. The controller then freezes the scanner and waits out contact bounce with its own timer. It accepts the press only if the key is still held when that wait ends. An accepted character enters a two-character history on the right, and the character that was there moves to the left digit.

After a press is accepted, the controller holds the scanner frozen until the key is released. A key held for any length of time is therefore recorded once. A short spike that is gone by the end of the debounce wait is dropped without touching the history. Both digits keep their values until the next accepted press.

The controller is a six-step Moore machine: scan, latch, settle, verify, commit and release. Its four control strobes are decoded from the current step alone. The debounce length is a parameter given in clock cycles. The default is 20 ms at 50 MHz.

Top module: `keypad_press_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `freeze_scan`, `dbnc_en`, `capture_en` and `disp_upd` are all low and both digits read 0.
- R2: `freeze_scan` is low only in the scan step. A high `key_hit` sampled in the scan step raises `freeze_scan` at the next edge, with all three strobes still low for that one latch cycle.
- R3: `dbnc_en` rises in the cycle after the latch cycle and stays high for exactly DBNC_CYCLES consecutive cycles.
- R4: `capture_en` is high for exactly the one cycle that follows the last `dbnc_en` cycle.
- R5: If `key_hit` is low in the `capture_en` cycle, the next cycle is back in the scan step (`freeze_scan` low), no `disp_upd` pulse follows and both digits are unchanged. With DBNC_CYCLES = N, a key held for N+2 clock edges from its first sampled edge is rejected.
- R6: If `key_hit` is high in the `capture_en` cycle, `disp_upd` pulses for one cycle next. At the end of that pulse, `digit_left` takes the old `digit_right`, and `digit_right` takes the `key_code` that was present during the `capture_en` cycle. With DBNC_CYCLES = N, a key held for N+3 edges is accepted.
- R7: After the `disp_upd` pulse, `freeze_scan` stays high while `key_hit` is high. It falls at the edge after `key_hit` is first sampled low, so a held key produces exactly one `disp_upd` pulse.
- R8: The digits change only at the end of a `disp_upd` cycle.
- R9: At most one of `dbnc_en`, `capture_en` and `disp_upd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_hit | input | 1 | Key-detected flag from the row scanner |
| key_code | input | CODE_W | Code of the detected key |
| freeze_scan | output | 1 | Stops the row scanner (low only while scanning) |
| capture_en | output | 1 | Key-capture strobe (verify step) |
| dbnc_en | output | 1 | Debounce timer running (settle step) |
| disp_upd | output | 1 | Display-update strobe (commit step) |
| digit_left | output | CODE_W | Older character, left digit |
| digit_right | output | CODE_W | Newest character, right digit |

## Verification
Clean directed presses, some held well past the debounce time, show that each press shifts the history once and that a long hold does not register twice. Spikes shorter than the debounce wait, and the two hold lengths one cycle either side of the acceptance edge, separate a correct verify decision from one taken a cycle early or late. Random press lengths, gaps and bursts of bounce toggles are then compared cycle by cycle against a bench model of the step sequence. This catches wrong strobe timing, a missed return to scanning and a wrong shift direction.

// File: rtl/kp_press_pkg.sv
package kp_press_pkg;

  typedef enum logic [2:0] {
    KP_SCAN    = 3'd0,
    KP_LATCH   = 3'd1,
    KP_SETTLE  = 3'd2,
    KP_VERIFY  = 3'd3,
    KP_COMMIT  = 3'd4,
    KP_RELEASE = 3'd5
  } kp_state_e;

  // Next step of the press controller.
  function automatic kp_state_e kp_step(kp_state_e cur, logic hit, logic settled);
    kp_state_e nxt;
    nxt = cur;
    case (cur)
      KP_SCAN:    if (hit) nxt = KP_LATCH;
      KP_LATCH:   nxt = KP_SETTLE;
      KP_SETTLE:  if (settled) nxt = KP_VERIFY;
      KP_VERIFY:  nxt = hit ? KP_COMMIT : KP_SCAN;
      KP_COMMIT:  nxt = KP_RELEASE;
      KP_RELEASE: if (!hit) nxt = KP_SCAN;
      default:    nxt = KP_SCAN;
    endcase
    return nxt;
  endfunction

  // Counter width able to hold values 0 .. n-1.
  function automatic int kp_cnt_w(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/kp_dbnc_timer.sv
module kp_dbnc_timer #(
  parameter int DBNC_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  import kp_press_pkg::*;

  localparam int CW = kp_cnt_w(DBNC_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DBNC_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign done    = run && at_last;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!at_last) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/kp_ctrl_fsm.sv
module kp_ctrl_fsm (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    key_hit,
  input  logic                    settled,
  output kp_press_pkg::kp_state_e state,
  output logic                    freeze,
  output logic                    settle_run,
  output logic                    capture,
  output logic                    commit
);
  import kp_press_pkg::*;

  kp_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= KP_SCAN;
    else     state_q <= kp_step(state_q, key_hit, settled);
  end

  always_comb begin
    freeze     = (state_q != KP_SCAN);
    settle_run = (state_q == KP_SETTLE);
    capture    = (state_q == KP_VERIFY);
    commit     = (state_q == KP_COMMIT);
  end

  assign state = state_q;

endmodule

// File: rtl/kp_char_history.sv
module kp_char_history #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              commit,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] older,
  output logic [CODE_W-1:0] newer
);
  logic [CODE_W-1:0] pend_q;
  logic [CODE_W-1:0] old_q;
  logic [CODE_W-1:0] new_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      old_q  <= '0;
      new_q  <= '0;
    end else begin
      if (capture) pend_q <= code_in;
      if (commit) begin
        old_q <= new_q;
        new_q <= pend_q;
      end
    end
  end

  assign older = old_q;
  assign newer = new_q;

endmodule

// File: rtl/keypad_press_ctrl.sv
module keypad_press_ctrl #(
  parameter int CODE_W      = 4,
  parameter int DBNC_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_hit,
  input  logic [CODE_W-1:0] key_code,
  output logic              freeze_scan,
  output logic              capture_en,
  output logic              dbnc_en,
  output logic              disp_upd,
  output logic [CODE_W-1:0] digit_left,
  output logic [CODE_W-1:0] digit_right
);
  import kp_press_pkg::*;

  // Internal events brought out for the bound checker.
  kp_state_e fsm_state;
  logic      dbnc_done;

  kp_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .key_hit    (key_hit),
    .settled    (dbnc_done),
    .state      (fsm_state),
    .freeze     (freeze_scan),
    .settle_run (dbnc_en),
    .capture    (capture_en),
    .commit     (disp_upd)
  );

  kp_dbnc_timer #(.DBNC_CYCLES(DBNC_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (dbnc_en),
    .done (dbnc_done)
  );

  kp_char_history #(.CODE_W(CODE_W)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .capture (capture_en),
    .commit  (disp_upd),
    .code_in (key_code),
    .older   (digit_left),
    .newer   (digit_right)
  );

endmodule

// File: rtl/kp_press_ctrl_chk.sv
module kp_press_ctrl_chk #(
  parameter int CODE_W      = 4,
  parameter int DBNC_CYCLES = 1000000
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    key_hit,
  input logic                    freeze_scan,
  input logic                    capture_en,
  input logic                    dbnc_en,
  input logic                    disp_upd,
  input logic                    dbnc_done,
  input kp_press_pkg::kp_state_e fsm_state,
  input logic [CODE_W-1:0]       digit_left,
  input logic [CODE_W-1:0]       digit_right
);
  import kp_press_pkg::*;

  localparam int RW = kp_cnt_w(DBNC_CYCLES + 1) + 1;

  // Length of the current dbnc_en run.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !dbnc_en) run_q <= '0;
    else                 run_q <= run_q + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!freeze_scan && !dbnc_en && !capture_en && !disp_upd &&
                    digit_left == '0 && digit_right == '0)); // R1

  AST_SCAN_TO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (!freeze_scan && key_hit) |=> (freeze_scan && !dbnc_en && !capture_en && !disp_upd)); // R2

  AST_DBNC_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(dbnc_en) |-> (run_q == RW'(DBNC_CYCLES))); // R3

  AST_CAPTURE_AFTER_DBNC: assert property (@(posedge clk) disable iff (rst)
    (dbnc_en && dbnc_done) |=> capture_en); // R4

  AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (capture_en && !key_hit) |=> (!freeze_scan && !disp_upd)); // R5

  AST_ACCEPT_COMMITS: assert property (@(posedge clk) disable iff (rst)
    (capture_en && key_hit) |=> disp_upd); // R6

  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
    disp_upd |=> (digit_left == $past(digit_right))); // R6

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == KP_RELEASE && key_hit) |=> (freeze_scan && !disp_upd)); // R7

  AST_RELEASE_TO_SCAN: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == KP_RELEASE && !key_hit) |=> !freeze_scan); // R7

  AST_DIGITS_STABLE: assert property (@(posedge clk) disable iff (rst)
    !disp_upd |=> $stable({digit_left, digit_right})); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dbnc_en, capture_en, disp_upd})); // R9

endmodule

bind keypad_press_ctrl kp_press_ctrl_chk #(
  .CODE_W(CODE_W), .DBNC_CYCLES(DBNC_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .key_hit     (key_hit),
  .freeze_scan (freeze_scan),
  .capture_en  (capture_en),
  .dbnc_en     (dbnc_en),
  .disp_upd    (disp_upd),
  .dbnc_done   (dbnc_done),
  .fsm_state   (fsm_state),
  .digit_left  (digit_left),
  .digit_right (digit_right)
);

// File: tb/tb_keypad_press_ctrl.sv
module tb_keypad_press_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          key_hit = 1'b0;
  logic [CW-1:0] key_code = '0;
  logic          freeze_scan, capture_en, dbnc_en, disp_upd;
  logic [CW-1:0] digit_left, digit_right;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_press_ctrl #(.CODE_W(CW), .DBNC_CYCLES(N)) dut (
    .clk(clk), .rst(rst), .key_hit(key_hit), .key_code(key_code),
    .freeze_scan(freeze_scan), .capture_en(capture_en), .dbnc_en(dbnc_en),
    .disp_upd(disp_upd), .digit_left(digit_left), .digit_right(digit_right)
  );

  // Reference model of the requirements: 0 scan, 1 latch, 2 settle,
  // 3 verify, 4 commit, 5 release.
  int          m_st = 0;
  int          m_cnt = 0;
  logic [CW-1:0] m_pend = '0, m_left = '0, m_right = '0;

  function automatic int ref_next(int st, bit hit, int cnt);
    case (st)
      0: return hit ? 1 : 0;
      1: return 2;
      2: return (cnt == N - 1) ? 3 : 2;
      3: return hit ? 4 : 0;
      4: return 5;
      5: return hit ? 5 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pend = '0; m_left = '0; m_right = '0;
    end else begin
      int nxt;
      nxt = ref_next(m_st, key_hit, m_cnt);
      if (m_st == 3) m_pend = key_code;
      if (m_st == 4) begin m_left = m_right; m_right = m_pend; end
      m_cnt = (m_st == 2 && nxt == 2) ? m_cnt + 1 : 0;
      if (disp_upd) pulses++;
      m_st = nxt;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(freeze_scan == (m_st != 0), "R2", "freeze_scan", freeze_scan, m_st != 0);
      chk(dbnc_en == (m_st == 2), "R3", "dbnc_en", dbnc_en, m_st == 2);
      chk(capture_en == (m_st == 3), "R4", "capture_en", capture_en, m_st == 3);
      chk(disp_upd == (m_st == 4), "R6", "disp_upd", disp_upd, m_st == 4);
      chk(digit_left == m_left, "R8", "digit_left", digit_left, m_left);
      chk(digit_right == m_right, "R8", "digit_right", digit_right, m_right);
      chk($countones({dbnc_en, capture_en, disp_upd}) <= 1, "R9", "strobes",
          $countones({dbnc_en, capture_en, disp_upd}), 1);
    end
  end

  task automatic press(logic [CW-1:0] code, int hold, int gap);
    @(negedge clk);
    key_code = code; key_hit = 1'b1;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk);
    key_hit = 1'b0; key_code = $urandom_range(0, 15);
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_digits(string tag, logic [CW-1:0] l, logic [CW-1:0] r);
    @(negedge clk);
    chk(digit_left == l, tag, "left digit", digit_left, l);
    chk(digit_right == r, tag, "right digit", digit_right, r);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!freeze_scan && !dbnc_en && !capture_en && !disp_upd, "R1", "strobes in reset",
        {freeze_scan, dbnc_en, capture_en, disp_upd}, 0);
    chk(digit_left == 0 && digit_right == 0, "R1", "digits in reset",
        {digit_left, digit_right}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!freeze_scan && digit_left == 0 && digit_right == 0, "R1", "after reset",
        {freeze_scan, digit_left, digit_right}, 0);

    press(4'h5, 20, 6);
    expect_digits("R6", 4'h0, 4'h5);
    pulses = 0;
    press(4'hA, 60, 6);
    expect_digits("R6", 4'h5, 4'hA);
    chk(pulses == 1, "R7", "pulses for long hold", pulses, 1);
    press(4'h3, 3, 12);
    expect_digits("R5", 4'h5, 4'hA);
    pulses = 0;
    press(4'h7, N + 2, 12);
    expect_digits("R5", 4'h5, 4'hA);
    chk(pulses == 0, "R5", "pulses at N+2 hold", pulses, 0);
    press(4'hC, N + 3, 6);
    expect_digits("R6", 4'hA, 4'hC);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        for (int b = 0; b < 10; b++) begin
          @(negedge clk);
          key_hit = $urandom_range(0, 1);
          key_code = $urandom_range(0, 15);
        end
      end
      press($urandom_range(0, 15), $urandom_range(1, 25), $urandom_range(1, 8));
    end
    repeat (4) @(negedge clk);
    chk(digit_left == m_left && digit_right == m_right, "R6", "history after random",
        {digit_left, digit_right}, {m_left, m_right});

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule